// File: doc/BRIEF.md
# I2C Byte Engine

This block is a master-side engine for a two-wire serial bus. It carries out one bus operation per command: a start condition, a stop condition, an eight-bit transmit with acknowledge sampling, an eight-bit receive that ends with an acknowledge bit chosen by the caller, or a recovery sequence that clocks a stuck bus free. The clock line is driven push-pull. The data line is open-drain: the block either pulls it low or lets go of it, and it reads the resolved level back on a separate input.

All bus edges fall on a grid of quarter periods. A quarter lasts `quarter_div` clock cycles, and a value of zero counts as one. Commands arrive on a valid/ready handshake that is only ready while the engine is idle. Each finished command raises `done` for one cycle. In that cycle the received byte and the sampled acknowledge level are valid.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset `scl_o` is 1, `sda_oe` is 0, `cmd_ready` is 1 and `done` is 0.
- R2: One quarter lasts `quarter_div` clock cycles, and a `quarter_div` of 0 gives quarters of one cycle.
- R3: Opcodes are START=0, STOP=1, WRITE=2, READ=3, RECOVER=4. Counted in quarters, the commands last START 4, STOP 4, WRITE 37, READ 29 and RECOVER 40. `done` is high for exactly one cycle, and it is seen that many cycles after the accepting clock edge.
- R4: START releases SDA, raises SCL, and then pulls SDA low while SCL stays high. It ends with SCL high and the line low.
- R5: STOP lowers SCL, pulls SDA low, raises SCL, and then releases SDA while SCL is high. It ends with both lines high.
- R6: WRITE shifts `cmd_wdata` out most significant bit first. Each bit has two quarters of SCL low, with SDA set in the second of them, and then two quarters of SCL high. During WRITE and READ, SDA never changes while SCL is high.
- R7: On the ninth clock of a WRITE the engine releases SDA and samples the line at the end of the high time. `ack_nack` reports that level: 0 means acknowledged and 1 means not acknowledged.
- R8: READ releases SDA and takes eight bits, most significant bit first. Each bit is sampled one quarter after the SCL rising edge, and the byte appears on `rdata` with `done`.
- R9: On the ninth clock of a READ the engine drives `cmd_nack` onto SDA: 0 pulls the line low and 1 leaves it high.
- R10: RECOVER releases SDA and gives nine clock pulses, each two quarters low and two quarters high. A STOP follows, so ten SCL rising edges appear and the command ends with both lines high.
- R11: `cmd_ready` is 0 from the cycle after an accept until `done`. A `cmd_valid` raised in that time starts nothing.
- R12: An opcode from 5 to 7 is never accepted. `cmd_ready` stays 1, no `done` follows, and neither line moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quarter_div | input | DIVW | Cycles per quarter SCL period (0 treated as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Opcode (see R3) |
| cmd_wdata | input | 8 | Byte to transmit for WRITE |
| cmd_nack | input | 1 | Acknowledge level to send after READ |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last received byte |
| ack_nack | output | 1 | SDA level sampled on the WRITE acknowledge clock |
| scl_o | output | 1 | Bus clock level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Resolved SDA level |

## Verification
The bound checker looks at every cycle. It confirms that quarter ticks come exactly one quarter length apart, that `done` is a single-cycle pulse raised only while idle, that an accept makes the engine busy, that an illegal opcode leaves both lines still, and that SDA never moves under a high SCL during byte transfers. Some things only the directed scenarios can show, because they need a bus partner: the bit order on the wire, the acknowledge levels in both directions, the start and stop conditions on the resolved line, the nine-plus-one clocks of recovery, and the total length of each command.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int BYTE_BITS   = 8;
  localparam int RECOV_PULSE = 9;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_RECOVER = 3'd4
  } op_e;

  // one quarter-boundary action on the two lines
  typedef struct packed {
    logic scl_set;
    logic scl_val;
    logic sda_set;
    logic sda_pull;
  } line_act_t;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'(OP_RECOVER);
  endfunction

  // number of bit slots per command
  function automatic logic [3:0] bits_of(input op_e op);
    case (op)
      OP_WRITE, OP_READ: return 4'(BYTE_BITS + 1);
      OP_RECOVER:        return 4'(RECOV_PULSE + 1);
      default:           return 4'd1;
    endcase
  endfunction

  // number of quarters in a given bit slot
  function automatic logic [2:0] quarters_of(input op_e op, input logic [3:0] b);
    case (op)
      OP_WRITE: return (b == 4'(BYTE_BITS)) ? 3'd5 : 3'd4;
      OP_READ:  return (b == 4'(BYTE_BITS)) ? 3'd5 : 3'd3;
      default:  return 3'd4;
    endcase
  endfunction

  function automatic line_act_t stop_act(input logic [2:0] q);
    line_act_t a;
    a = '0;
    case (q)
      3'd0: begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
      3'd1: begin a.sda_set = 1'b1; a.sda_pull = 1'b1; end
      3'd2: begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
      3'd3: begin a.sda_set = 1'b1; a.sda_pull = 1'b0; end
      default: ;
    endcase
    return a;
  endfunction

  // action applied at the start of quarter q of bit slot b
  function automatic line_act_t act_of(input op_e op, input logic [3:0] b,
                                       input logic [2:0] q, input logic tx,
                                       input logic ak);
    line_act_t a;
    a = '0;
    case (op)
      OP_START: begin
        if (q == 3'd1) begin a.sda_set = 1'b1; a.sda_pull = 1'b0; end
        if (q == 3'd2) begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
        if (q == 3'd3) begin a.sda_set = 1'b1; a.sda_pull = 1'b1; end
      end
      OP_STOP: a = stop_act(q);
      OP_RECOVER: begin
        if (b == 4'(RECOV_PULSE)) a = stop_act(q);
        else begin
          if (q == 3'd0) begin
            a.scl_set = 1'b1; a.scl_val = 1'b0;
            a.sda_set = 1'b1; a.sda_pull = 1'b0;
          end
          if (q == 3'd2) begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
        end
      end
      OP_WRITE: begin
        if (q == 3'd0) begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
        if (q == 3'd1) begin
          a.sda_set  = 1'b1;
          a.sda_pull = (b < 4'(BYTE_BITS)) ? ~tx : 1'b0;
        end
        if (q == 3'd2) begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
        if (q == 3'd4) begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
      end
      OP_READ: begin
        if (b < 4'(BYTE_BITS)) begin
          if (q == 3'd0) begin
            a.scl_set = 1'b1; a.scl_val = 1'b0;
            a.sda_set = 1'b1; a.sda_pull = 1'b0;
          end
          if (q == 3'd1) begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
        end else begin
          if (q == 3'd0) begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
          if (q == 3'd1) begin a.sda_set = 1'b1; a.sda_pull = ~ak; end
          if (q == 3'd2) begin a.scl_set = 1'b1; a.scl_val = 1'b1; end
          if (q == 3'd4) begin a.scl_set = 1'b1; a.scl_val = 1'b0; end
        end
      end
      default: ;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] reload;

  always_comb begin
    reload = (div == '0) ? '0 : div - 1'b1;
    tick   = run && !restart && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= reload;
    else if (run)     cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_step_ctr.sv
module i2c_step_ctr import i2c_eng_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       adv,
  input  op_e        op,
  output logic [3:0] bit_idx,
  output logic [2:0] qtr_idx,
  output logic [3:0] nxt_bit,
  output logic [2:0] nxt_qtr,
  output logic       at_end
);
  logic last_q, last_b;

  always_comb begin
    last_q  = (qtr_idx == quarters_of(op, bit_idx) - 3'd1);
    last_b  = (bit_idx == bits_of(op) - 4'd1);
    at_end  = last_q && last_b;
    nxt_bit = last_q ? bit_idx + 4'd1 : bit_idx;
    nxt_qtr = last_q ? 3'd0 : qtr_idx + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      qtr_idx <= '0;
    end else if (load) begin
      bit_idx <= '0;
      qtr_idx <= '0;
    end else if (adv && !at_end) begin
      bit_idx <= nxt_bit;
      qtr_idx <= nxt_qtr;
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine import i2c_eng_pkg::*; #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] quarter_div,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [7:0]      cmd_wdata,
  input  logic            cmd_nack,
  output logic            done,
  output logic [7:0]      rdata,
  output logic            ack_nack,
  output logic            scl_o,
  output logic            sda_oe,
  input  logic            sda_i
);
  localparam int BW = BYTE_BITS;

  logic            busy;
  op_e             cur_op;
  logic [BW-1:0]   wbyte;
  logic [BW-1:0]   rshift;
  logic            ack_q;
  logic            accept;
  logic            q_tick;
  logic [3:0]      bit_idx, nxt_bit;
  logic [2:0]      qtr_idx, nxt_qtr;
  logic            at_end;
  logic            txbit;
  logic            w_sample, r_sample;
  line_act_t       act;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy && op_legal(cmd_op);

  i2c_qtick #(.DIVW(DIVW)) u_qtick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
    .div(quarter_div), .tick(q_tick)
  );

  i2c_step_ctr u_step (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(q_tick), .op(cur_op),
    .bit_idx(bit_idx), .qtr_idx(qtr_idx), .nxt_bit(nxt_bit),
    .nxt_qtr(nxt_qtr), .at_end(at_end)
  );

  always_comb begin
    txbit = (nxt_bit < 4'(BW)) ? wbyte[3'(BW-1) - nxt_bit[2:0]] : 1'b1;
    if (accept) act = act_of(op_e'(cmd_op), 4'd0, 3'd0, cmd_wdata[BW-1], cmd_nack);
    else        act = act_of(cur_op, nxt_bit, nxt_qtr, txbit, ack_q);
    w_sample = q_tick && (cur_op == OP_WRITE) && (bit_idx == 4'(BW)) && (qtr_idx == 3'd3);
    r_sample = q_tick && (cur_op == OP_READ) && (bit_idx < 4'(BW)) && (qtr_idx == 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_op   <= OP_START;
      wbyte    <= '0;
      rshift   <= '0;
      ack_q    <= 1'b1;
      done     <= 1'b0;
      rdata    <= '0;
      ack_nack <= 1'b0;
      scl_o    <= 1'b1;
      sda_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cur_op <= op_e'(cmd_op);
        wbyte  <= cmd_wdata;
        ack_q  <= cmd_nack;
        if (act.scl_set) scl_o  <= act.scl_val;
        if (act.sda_set) sda_oe <= act.sda_pull;
      end else if (q_tick) begin
        if (w_sample) ack_nack <= sda_i;
        if (r_sample) rshift   <= {rshift[BW-2:0], sda_i};
        if (at_end) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (cur_op == OP_READ) rdata <= rshift;
        end else begin
          if (act.scl_set) scl_o  <= act.scl_val;
          if (act.sda_set) sda_oe <= act.sda_pull;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk import i2c_eng_pkg::*; #(
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DIVW-1:0] quarter_div,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic            cmd_ready,
  input logic            done,
  input logic            scl_o,
  input logic            sda_oe,
  input logic            q_tick,
  input logic            busy,
  input logic            accept,
  input logic [2:0]      cur_op
);
  logic [DIVW:0] gap;
  logic [DIVW:0] div_eff;

  assign div_eff = (quarter_div == '0) ? (DIVW+1)'(1) : {1'b0, quarter_div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (accept) gap <= (DIVW+1)'(1);
    else if (busy)   gap <= q_tick ? (DIVW+1)'(1) : gap + 1'b1;
  end

  // R2
  quarter_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_tick |-> (gap == div_eff));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !cmd_ready));

  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op > 3'd4)) |=> (cmd_ready && $stable(scl_o) && $stable(sda_oe)));

  // R6
  sda_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scl_o && $past(scl_o) && (sda_oe != $past(sda_oe)))
      |-> ((cur_op != 3'(OP_WRITE)) && (cur_op != 3'(OP_READ))));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_ready(cmd_ready), .done(done), .scl_o(scl_o),
  .sda_oe(sda_oe), .q_tick(q_tick), .busy(busy), .accept(accept),
  .cur_op(cur_op)
);

// File: tb/i2c_byte_engine_test.sv
module i2c_byte_engine_test;
  localparam int DIVW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIVW-1:0] quarter_div = 8'd2;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic cmd_nack = 1'b1;
  logic cmd_ready, done, ack_nack, scl_o, sda_oe, sda_i;
  logic [7:0] rdata;

  // slave model state
  int slv_mode = 0;          // 0 passive, 1 ack ninth clock, 2 send byte
  logic [7:0] slv_byte = 8'h00;
  int slv_r = 0;
  logic slv_low = 1'b0;

  assign sda_i = ~(sda_oe | slv_low);

  i2c_byte_engine #(.DIVW(DIVW)) uut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_nack(cmd_nack), .done(done), .rdata(rdata), .ack_nack(ack_nack),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bus monitor
  int start_cnt = 0, stop_cnt = 0, rise_cnt = 0, last_high = 0, rise_at = 0;
  logic [8:0] rise_bits = '0;
  logic p_scl = 1'b1, p_line = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired: actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_o && p_scl && p_line && !sda_i) start_cnt++;
      if (scl_o && p_scl && !p_line && sda_i) stop_cnt++;
      if (scl_o && !p_scl) begin
        rise_cnt++;
        rise_bits = {rise_bits[7:0], sda_i};
        rise_at = cyc;
      end
      if (!scl_o && p_scl) last_high = cyc - rise_at;
    end
    p_scl = scl_o;
    p_line = sda_i;
  end

  task automatic slv_update();
    case (slv_mode)
      1: slv_low = (slv_r == 8);
      2: slv_low = (slv_r < 8) ? !slv_byte[7 - slv_r] : 1'b0;
      default: slv_low = 1'b0;
    endcase
  endtask

  always @(posedge scl_o) slv_r = slv_r + 1;
  always @(negedge scl_o) slv_update();

  task automatic slv_arm(input int mode, input logic [7:0] b);
    slv_mode = mode;
    slv_byte = b;
    slv_r = 0;
    slv_update();
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic nk,
                         output int ncyc);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_wdata = wd; cmd_nack = nk; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    ncyc = 0;
    while (!done && ncyc < 5000) begin
      @(posedge clk);
      ncyc++;
      @(negedge clk);
    end
  endtask

  function automatic int qlen();
    return (quarter_div == 0) ? 1 : int'(quarter_div);
  endfunction

  task automatic t_reset();
    chk(scl_o === 1'b1 && sda_oe === 1'b0, "R1 lines after reset", {scl_o, sda_oe}, 2'b10);
    chk(cmd_ready === 1'b1 && done === 1'b0, "R1 handshake after reset", {cmd_ready, done}, 2'b10);
  endtask

  task automatic t_start();
    int n, s0;
    s0 = start_cnt;
    run_cmd(3'd0, 8'h00, 1'b1, n);
    chk(n == 4 * qlen(), "R3 START length", n, 4 * qlen());
    chk(scl_o && !sda_i, "R4 START end state", {scl_o, sda_i}, 2'b10);
    chk(start_cnt == s0 + 1, "R4 start condition seen", start_cnt - s0, 1);
  endtask

  task automatic t_stop();
    int n, s0;
    s0 = stop_cnt;
    run_cmd(3'd1, 8'h00, 1'b1, n);
    chk(n == 4 * qlen(), "R3 STOP length", n, 4 * qlen());
    chk(scl_o && sda_i, "R5 STOP end state", {scl_o, sda_i}, 2'b11);
    chk(stop_cnt == s0 + 1, "R5 stop condition seen", stop_cnt - s0, 1);
  endtask

  task automatic t_write(input logic [7:0] b, input bit slave_acks);
    int n, r0, s0, p0;
    slv_arm(slave_acks ? 1 : 0, 8'h00);
    r0 = rise_cnt; s0 = start_cnt; p0 = stop_cnt;
    run_cmd(3'd2, b, 1'b1, n);
    chk(n == 37 * qlen(), "R3 WRITE length", n, 37 * qlen());
    chk(rise_cnt == r0 + 9, "R6 WRITE clock count", rise_cnt - r0, 9);
    chk(rise_bits[8:1] == b, "R6 WRITE bits on wire", rise_bits[8:1], b);
    chk(last_high == 2 * qlen(), "R6 WRITE SCL high time", last_high, 2 * qlen());
    chk(start_cnt == s0 && stop_cnt == p0, "R6 no SDA change under high SCL",
        start_cnt - s0 + stop_cnt - p0, 0);
    chk(ack_nack == !slave_acks, "R7 WRITE acknowledge level", ack_nack, !slave_acks);
    slv_arm(0, 8'h00);
  endtask

  task automatic t_read(input logic [7:0] b, input logic nk);
    int n;
    slv_arm(2, b);
    run_cmd(3'd3, 8'h00, nk, n);
    chk(n == 29 * qlen(), "R3 READ length", n, 29 * qlen());
    chk(rdata == b, "R8 READ byte", rdata, b);
    chk(rise_bits[0] == nk, "R9 READ acknowledge driven", rise_bits[0], nk);
    slv_arm(0, 8'h00);
  endtask

  task automatic t_recover();
    int n, r0, p0;
    r0 = rise_cnt; p0 = stop_cnt;
    run_cmd(3'd4, 8'h00, 1'b1, n);
    chk(n == 40 * qlen(), "R3 RECOVER length", n, 40 * qlen());
    chk(rise_cnt == r0 + 10, "R10 RECOVER clock count", rise_cnt - r0, 10);
    chk(stop_cnt == p0 + 1 && scl_o && sda_i, "R10 RECOVER ends in stop",
        stop_cnt - p0, 1);
  endtask

  task automatic t_div();
    int n;
    quarter_div = 8'd0;
    run_cmd(3'd0, 8'h00, 1'b1, n);
    chk(n == 4, "R2 zero divider clamps to one", n, 4);
    quarter_div = 8'd3;
    run_cmd(3'd1, 8'h00, 1'b1, n);
    chk(n == 12, "R2 quarter of three cycles", n, 12);
    quarter_div = 8'd2;
  endtask

  task automatic t_busy();
    int n, s0;
    logic saw_ready;
    s0 = start_cnt;
    @(negedge clk);
    cmd_op = 3'd2; cmd_wdata = 8'h55; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    repeat (3) begin @(posedge clk); n++; @(negedge clk); end
    saw_ready = cmd_ready;
    cmd_op = 3'd0; cmd_valid = 1'b1;
    repeat (2) begin @(posedge clk); n++; @(negedge clk); end
    cmd_valid = 1'b0;
    while (!done && n < 5000) begin @(posedge clk); n++; @(negedge clk); end
    chk(saw_ready == 1'b0, "R11 not ready while busy", saw_ready, 0);
    chk(n == 37 * qlen(), "R11 busy request ignored, length", n, 37 * qlen());
    chk(start_cnt == s0, "R11 no start issued", start_cnt - s0, 0);
  endtask

  task automatic t_badop();
    logic s0, d0;
    bit moved, seen_done, not_ready;
    s0 = scl_o; d0 = sda_oe;
    moved = 0; seen_done = 0; not_ready = 0;
    @(negedge clk);
    cmd_op = 3'd6; cmd_valid = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (scl_o != s0 || sda_oe != d0) moved = 1;
      if (done) seen_done = 1;
      if (!cmd_ready) not_ready = 1;
    end
    cmd_valid = 1'b0;
    chk(!not_ready && !seen_done, "R12 illegal opcode not taken", {not_ready, seen_done}, 0);
    chk(!moved, "R12 lines unchanged", moved, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_start();
    t_write(8'hA6, 1'b1);
    t_write(8'h3C, 1'b0);
    t_read(8'h5A, 1'b1);
    t_read(8'hC3, 1'b0);
    t_stop();
    t_div();
    t_start();
    t_recover();
    t_busy();
    t_badop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule